// File: doc/BRIEF.md
# System Control Register File

This block is a bank of 32-bit control and status words behind a simple word-addressed bus slave. The bus has a select, an enable, a write strobe, a byte address and write data. Most words store whatever is written to them and return it on a read. A few words behave differently:

- One PLL status word is read-only.
- Three memory-remap control words never change. A write that tries to change one of them raises a one-cycle "unsupported" pulse.

On reset, a few words load fixed status values. One word loads a clock-divider field that is built from two bus-divisor parameters. Accesses outside the window raise a one-cycle bad-access pulse, and a read outside the window returns zero.

The slave is driven by a two-state machine:

- `BUS_IDLE` waits for a setup cycle (select high, enable low). When it sees one, it takes the transition *setup-seen* to `BUS_ACCESS`. On that edge the read data and both pulses are registered.
- `BUS_ACCESS` always takes the transition *transfer-done* back to `BUS_IDLE`. On that edge a write is committed.
- Any other cycle in `BUS_IDLE` is the transition *idle-hold*, which stays in `BUS_IDLE`.

There are no wait states and no bus error response. Each divisor parameter must be a power of two from 1 to 32. Any other value stops elaboration.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, these words hold fixed values, and a read returns the value held:
  - byte offset 0x090 holds 0x021A2358;
  - byte offset 0x150 holds 0x00000003;
  - every word that is neither a fixed word nor the divider word holds zero.

  During reset, `prdata`, `bad_access` and `remap_unsupported` are zero.
- R2: After reset, the word at byte offset 0x098 holds a code in bits [7:5] for divisor `DIV_A` and a code in bits [4:2] for divisor `DIV_B`. All its other bits are zero. The code of a divisor d is:
  - below 8, the number of trailing zero bits of d;
  - 8 and above, that number plus one.

  This gives 1→0, 2→1, 4→2, 8→4, 16→5 and 32→6.
- R3: A word that is read/write (every word except 0x000, 0x008, 0x010 and 0x150) returns on read the last value written to it. The word is selected by the byte address shifted right by two, so address bits [1:0] are ignored. The window is 0x300 bytes, which is 192 words.
- R4: A write to the PLL status word at 0x150 leaves its value unchanged.
- R5: A write to a remap word at 0x000, 0x008 or 0x010 leaves its value unchanged. `remap_unsupported` is high during the access phase of that write when the write data differs from the stored value, and low when it is equal.
- R6: An access at a byte offset of 0x300 or above raises `bad_access` during its access phase.
  - A read there returns zero.
  - A write there changes no word.
- R7: Read data is registered on the setup edge and is valid throughout the access phase. It holds until the next read. A write takes effect on the edge that ends its access phase, so a read in the transfer directly after it, with no idle cycle between, returns the new value.
- R8: `bad_access` and `remap_unsupported` are each high for at most one cycle, and only during an access phase. Both are low in the cycle after an access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | High in the access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| bad_access | output | 1 | Pulse for an out-of-window access |
| remap_unsupported | output | 1 | Pulse for a changing write to a remap word |

## Verification
The bench builds the block with `DIV_A` = 16 and `DIV_B` = 4. With these values the divider word should read 0xA8. The 16 case reaches the non-linear branch of the code, where it maps to 5 rather than 4. The 4 case exercises the trailing-zero branch and places a code different from the first one in the lower field, so a swapped or misplaced field shows up. The default `ADDR_W` of 12 lets the bench address both the last word in the window and offsets well past it, up to 0xFFC.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE   = 1'b0,
        BUS_ACCESS = 1'b1
    } bus_state_e;

    typedef enum logic [1:0] {
        POL_RW     = 2'd0,
        POL_RO     = 2'd1,
        POL_FROZEN = 2'd2
    } word_pol_e;

    localparam int unsigned BYTE_MAP_A    = 32'h000;
    localparam int unsigned BYTE_MAP_B    = 32'h008;
    localparam int unsigned BYTE_MAP_C    = 32'h010;
    localparam int unsigned BYTE_PLL_SNAP = 32'h090;
    localparam int unsigned BYTE_CLKDIV   = 32'h098;
    localparam int unsigned BYTE_PLL_STAT = 32'h150;

    localparam logic [31:0] RST_PLL_SNAP = 32'h021A_2358;
    localparam logic [31:0] RST_PLL_STAT = 32'h0000_0003;

    function automatic bit div_legal(int unsigned d);
        return (d != 0) && (d <= 32) && ((d & (d - 1)) == 0);
    endfunction

    function automatic logic [2:0] div_code(int unsigned d);
        int unsigned tz;
        bit          seen;
        tz   = 0;
        seen = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (!seen) begin
                if (d[i]) seen = 1'b1;
                else      tz   = tz + 1;
            end
        end
        return (d < 8) ? 3'(tz) : 3'(tz + 1);
    endfunction

    function automatic logic [31:0] clkdiv_word(int unsigned da, int unsigned db);
        return {24'h0, div_code(da), div_code(db), 2'b00};
    endfunction

    function automatic word_pol_e word_policy(int unsigned w);
        int unsigned b;
        b = w * 4;
        if (b == BYTE_PLL_STAT) return POL_RO;
        if (b == BYTE_MAP_A || b == BYTE_MAP_B || b == BYTE_MAP_C) return POL_FROZEN;
        return POL_RW;
    endfunction

    function automatic logic [31:0] word_reset(int unsigned w, logic [31:0] divcfg);
        int unsigned b;
        b = w * 4;
        if (b == BYTE_PLL_SNAP) return RST_PLL_SNAP;
        if (b == BYTE_PLL_STAT) return RST_PLL_STAT;
        if (b == BYTE_CLKDIV)   return divcfg;
        return 32'h0;
    endfunction

endpackage

// File: rtl/sysctl_bus_fsm.sv
module sysctl_bus_fsm
    import sysctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic cap_en,
    output logic commit_en
);

    bus_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        cap_en    = 1'b0;
        commit_en = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                if (psel && !penable) begin
                    cap_en  = 1'b1;
                    state_d = BUS_ACCESS;
                end
            end
            BUS_ACCESS: begin
                commit_en = psel && penable && pwrite;
                state_d   = BUS_IDLE;
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    // R7: the access state is only ever entered from a setup cycle seen while idle
    p_access_after_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_ACCESS) |-> $past(psel && !penable && state_q == BUS_IDLE));

    // R7: a transfer lasts exactly one access cycle
    p_access_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_ACCESS) |=> (state_q == BUS_IDLE));

endmodule

// File: rtl/sysctl_reg_bank.sv
module sysctl_reg_bank
    import sysctl_pkg::*;
#(
    parameter int unsigned NUM_WORDS  = 192,
    parameter int unsigned IDX_W      = 8,
    parameter logic [31:0] DIVCFG_RST = 32'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data
);

    logic [31:0] words [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam word_pol_e        POL    = word_policy(w);
        localparam logic [31:0]      RSTV   = word_reset(w, DIVCFG_RST);
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(w);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[w] <= RSTV;
            else if (wr_en && idx == MY_IDX && POL == POL_RW)
                words[w] <= wr_data;
        end

        if (POL != POL_RW) begin : g_locked
            // R4 (status word) and R5 (remap words): value never moves after reset
            p_locked_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $stable(words[w]));
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_WORDS; i++)
            if (idx == IDX_W'(i)) rd_data = words[i];
    end

endmodule

// File: rtl/sysctl_resp.sv
module sysctl_resp (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap_en,
    input  logic        is_write,
    input  logic        in_range,
    input  logic        frozen_hit,
    input  logic [31:0] rd_data,
    input  logic [31:0] wr_data,
    output logic [31:0] prdata,
    output logic        bad_access,
    output logic        remap_unsupported
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prdata            <= '0;
            bad_access        <= 1'b0;
            remap_unsupported <= 1'b0;
        end else begin
            bad_access        <= cap_en && !in_range;
            remap_unsupported <= cap_en && is_write && in_range && frozen_hit
                                 && (wr_data != rd_data);
            if (cap_en && !is_write)
                prdata <= in_range ? rd_data : 32'h0;
        end
    end

    // R8: each pulse lasts a single cycle
    p_bad_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |=> !bad_access);
    p_unsup_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        remap_unsupported |=> !remap_unsupported);
    // R5: an unsupported indication belongs to an in-window access
    p_unsup_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        remap_unsupported |-> !bad_access);

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned WINDOW_BYTES = 768,
    parameter int unsigned DIV_A        = 2,
    parameter int unsigned DIV_B        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              bad_access,
    output logic              remap_unsupported
);

    localparam int unsigned      NUM_WORDS = WINDOW_BYTES / 4;
    localparam int unsigned      IDX_W     = $clog2(NUM_WORDS);
    localparam logic [ADDR_W-1:0] LIMIT    = ADDR_W'(NUM_WORDS);
    localparam logic [31:0]      DIVCFG    = clkdiv_word(DIV_A, DIV_B);

    if (!div_legal(DIV_A) || !div_legal(DIV_B)) begin : g_bad_divisor
        $error("sysctl_regfile: divisors must be powers of two from 1 to 32");
    end
    if ((WINDOW_BYTES % 4) != 0 || (1 << ADDR_W) <= WINDOW_BYTES) begin : g_bad_window
        $error("sysctl_regfile: window must be whole words and smaller than the address space");
    end

    logic [ADDR_W-1:0] word_addr;
    logic              in_range;
    logic              frozen_hit;
    logic              cap_en;
    logic              commit_en;
    logic [31:0]       rd_data;

    always_comb begin
        word_addr  = paddr >> 2;
        in_range   = word_addr < LIMIT;
        frozen_hit = in_range && (word_policy(int'(word_addr)) == POL_FROZEN);
    end

    sysctl_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .cap_en    (cap_en),
        .commit_en (commit_en)
    );

    sysctl_reg_bank #(
        .NUM_WORDS  (NUM_WORDS),
        .IDX_W      (IDX_W),
        .DIVCFG_RST (DIVCFG)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit_en && in_range),
        .idx     (word_addr[IDX_W-1:0]),
        .wr_data (pwdata),
        .rd_data (rd_data)
    );

    sysctl_resp u_resp (
        .clk               (clk),
        .rst_n             (rst_n),
        .cap_en            (cap_en),
        .is_write          (pwrite),
        .in_range          (in_range),
        .frozen_hit        (frozen_hit),
        .rd_data           (rd_data),
        .wr_data           (pwdata),
        .prdata            (prdata),
        .bad_access        (bad_access),
        .remap_unsupported (remap_unsupported)
    );

    // R6: an out-of-window read returns zero during its access phase
    p_oob_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_access && psel && penable && !pwrite) |-> (prdata == 32'h0));

endmodule

// File: tb/sysctl_regfile_test.sv
`timescale 1ns/1ps
module sysctl_regfile_test;

    localparam int unsigned AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          bad_access;
    logic          remap_unsupported;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sysctl_regfile #(.ADDR_W(AW), .WINDOW_BYTES(768), .DIV_A(16), .DIV_B(4)) uut (
        .clk (clk), .rst_n (rst_n), .psel (psel), .penable (penable),
        .pwrite (pwrite), .paddr (paddr), .pwdata (pwdata), .prdata (prdata),
        .bad_access (bad_access), .remap_unsupported (remap_unsupported)
    );

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [31:0]   data;
        logic [31:0]   exp;
        logic          err;
        logic          uns;
        logic [15:0]   tag;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 12'h090, 32'h0,         32'h021A2358, 1'b0, 1'b0, "R1"},
        '{1'b0, 12'h150, 32'h0,         32'h00000003, 1'b0, 1'b0, "R1"},
        '{1'b0, 12'h098, 32'h0,         32'h000000A8, 1'b0, 1'b0, "R2"},
        '{1'b0, 12'h004, 32'h0,         32'h00000000, 1'b0, 1'b0, "R1"},
        '{1'b1, 12'h004, 32'hA5A50001, 32'h0,         1'b0, 1'b0, "R3"},
        '{1'b0, 12'h004, 32'h0,         32'hA5A50001, 1'b0, 1'b0, "R3"},
        '{1'b1, 12'h2FC, 32'h12345678, 32'h0,         1'b0, 1'b0, "R3"},
        '{1'b0, 12'h2FE, 32'h0,         32'h12345678, 1'b0, 1'b0, "R3"},
        '{1'b1, 12'h150, 32'h0000FFFF, 32'h0,         1'b0, 1'b0, "R4"},
        '{1'b0, 12'h150, 32'h0,         32'h00000003, 1'b0, 1'b0, "R4"},
        '{1'b1, 12'h000, 32'h00000001, 32'h0,         1'b0, 1'b1, "R5"},
        '{1'b0, 12'h000, 32'h0,         32'h00000000, 1'b0, 1'b0, "R5"},
        '{1'b1, 12'h008, 32'h00000000, 32'h0,         1'b0, 1'b0, "R5"},
        '{1'b1, 12'h010, 32'h0000DEAD, 32'h0,         1'b0, 1'b1, "R5"},
        '{1'b0, 12'h010, 32'h0,         32'h00000000, 1'b0, 1'b0, "R5"},
        '{1'b1, 12'h300, 32'hFFFFFFFF, 32'h0,         1'b1, 1'b0, "R6"},
        '{1'b0, 12'h300, 32'h0,         32'h00000000, 1'b1, 1'b0, "R6"},
        '{1'b0, 12'hFFC, 32'h0,         32'h00000000, 1'b1, 1'b0, "R6"},
        '{1'b0, 12'h2FC, 32'h0,         32'h12345678, 1'b0, 1'b0, "R6"},
        '{1'b1, 12'h098, 32'hFFFFFFFF, 32'h0,         1'b0, 1'b0, "R3"},
        '{1'b0, 12'h098, 32'h0,         32'hFFFFFFFF, 1'b0, 1'b0, "R3"},
        '{1'b0, 12'h0A4, 32'h0,         32'h00000000, 1'b0, 1'b0, "R1"}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Starts at a falling edge; samples in the access phase and in the cycle after it.
    task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic e, output logic u,
                        output logic pe, output logic pu);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1;
        rd = prdata; e = bad_access; u = remap_unsupported;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        #1;
        pe = bad_access; pu = remap_unsupported;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic e, u, pe, pu;

        repeat (3) @(negedge clk);
        // R1: outputs are quiet during reset
        check("R1 prdata in reset", prdata, 32'h0);
        check("R1 pulses in reset", {30'h0, bad_access, remap_unsupported}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i].wr, VEC[i].addr, VEC[i].data, rd, e, u, pe, pu);
            if (!VEC[i].wr) check($sformatf("%s data @%03h", VEC[i].tag, VEC[i].addr), rd, VEC[i].exp);
            check($sformatf("%s bad_access @%03h", VEC[i].tag, VEC[i].addr), {31'h0, e}, {31'h0, VEC[i].err});
            check($sformatf("%s remap_unsupported @%03h", VEC[i].tag, VEC[i].addr), {31'h0, u}, {31'h0, VEC[i].uns});
            // R8: both pulses low in the cycle after an access phase
            check("R8 pulses after access", {30'h0, pe, pu}, 32'h0);
        end

        // R7: back-to-back write then read of the same word, no idle between
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h00C; pwdata = 32'hCAFE0000;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); penable = 1'b0; pwrite = 1'b0;
        @(negedge clk); penable = 1'b1; #1;
        check("R7 back-to-back read", prdata, 32'hCAFE0000);
        @(negedge clk); psel = 1'b0; penable = 1'b0; #1;
        check("R7 prdata held after transfer", prdata, 32'hCAFE0000);
        // R7: a write transfer leaves the read data register alone
        @(negedge clk);
        xfer(1'b1, 12'h020, 32'h11111111, rd, e, u, pe, pu);
        check("R7 prdata after write", prdata, 32'hCAFE0000);

        // R1/R2: a second reset restores defaults
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        xfer(1'b0, 12'h004, 32'h0, rd, e, u, pe, pu);
        check("R1 word zero after second reset", rd, 32'h0);
        xfer(1'b0, 12'h098, 32'h0, rd, e, u, pe, pu);
        check("R2 divider word after second reset", rd, 32'h000000A8);

        // R8: no pulses while the bus is idle
        repeat (3) @(negedge clk);
        #1;
        check("R8 pulses while idle", {30'h0, bad_access, remap_unsupported}, 32'h0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule